// File: doc/BRIEF.md
# Dual Digital Phase Detector

This block supplies the phase-error signals for a fully digital phase-locked loop. It has two detectors, and both share the feedback input. The first detector compares a reference input with the feedback input through a plain exclusive-OR. Its output is combinational and needs no clock. The second detector is a registered set/reset element. It samples its reference input and the feedback input on the system clock and detects the selected transition by comparing successive samples. A transition on the feedback input sets its output. A transition on the reference input clears it. At all other times it holds its value. Either output can drive the up/down control of the loop counter.

The two detectors differ in gain and in where zero error sits. The exclusive-OR detector has a gain of 4 per cycle of phase error, and its zero-error point lies at a quarter-cycle offset between its inputs. The set/reset detector has a gain of 2 per cycle, and its zero-error point lies at a half-cycle offset. At zero error, each detector produces a square wave with a 50% duty cycle. At the edge of the linear range, the output stays high or low continuously. Each input of the registered detector passes through a synchronizer of `SYNC_STAGES` flops. `FALL_EDGE` selects falling edges (default) or rising edges as the active transition.

Top module: `dual_phase_det`

## Requirements
- R1: `xor_err` is 1 exactly when `ref_x` and `fb_in` differ, and 0 when they are equal, in the same cycle with no clock involved.
- R2: With the default falling-edge selection, a 1-to-0 change on `fb_in` drives `edge_err` to 1. This happens when `ref_e` does not also fall in the same sample. `edge_err` changes at the (`SYNC_STAGES`+1)-th rising clock edge after the change on the input.
- R3: With the default selection, a 1-to-0 change on `ref_e` drives `edge_err` to 0. This happens when `fb_in` does not also fall in the same sample. The latency is the same as in R2.
- R4: When `ref_e` and `fb_in` both fall in the same sample, `edge_err` keeps its previous value, whether that value is 0 or 1.
- R5: Rising edges and steady levels on `ref_e` or `fb_in` leave `edge_err` unchanged.
- R6: While `rst` (active-high, synchronous) is 1, `edge_err` is 0 after each clock edge. The synchronizer and edge history are cleared, so inputs held high through reset and after its release create no transition.
- R7: Zero-error inputs give a 50% duty cycle on both outputs. With period-8 square waves, `ref_x` leads `fb_in` by 2 cycles and `ref_e` leads `fb_in` by 4 cycles. Under these inputs, each output is high for 16 of any 32 consecutive cycles in steady state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_x | input | 1 | Reference input of the exclusive-OR detector |
| ref_e | input | 1 | Reference input of the edge detector (clears output) |
| fb_in | input | 1 | Shared feedback input (sets edge detector output) |
| xor_err | output | 1 | Exclusive-OR phase error, combinational |
| edge_err | output | 1 | Registered set/reset phase error |

## Verification
The exclusive-OR result is due in the same cycle as its inputs. The bench drives inputs at the falling clock edge and reads `xor_err` one nanosecond later, before any rising edge. The registered result is due `SYNC_STAGES`+1 rising edges after an input change: the synchronizer flops, then the history/output register. The bench reference model pushes every sample through a behavioural delay line of that depth and compares `edge_err` at every falling edge. This covers the latency as well as the set, clear and hold decisions. The duty-cycle check counts high samples over a whole number of periods, but only after the pipeline has filled.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    // One sample of the two inputs that feed the registered detector
    typedef struct packed {
        logic ref_s;   // clearing input
        logic fb_s;    // setting input
    } pd_pair_t;

    // Decision taken by the set/reset core at a clock edge
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_SET   = 2'd1,
        CMD_CLEAR = 2'd2
    } sr_cmd_t;

    // Active transition between two successive samples
    function automatic logic edge_hit(input logic prev, input logic cur,
                                      input logic fall_sel);
        return fall_sel ? (prev & ~cur) : (~prev & cur);
    endfunction

    // Feedback edge sets, reference edge clears, simultaneous edges hold
    function automatic sr_cmd_t decide(input pd_pair_t hits);
        sr_cmd_t c;
        unique case ({hits.fb_s, hits.ref_s})
            2'b10:   c = CMD_SET;
            2'b01:   c = CMD_CLEAR;
            default: c = CMD_HOLD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dpd_sync.sv
module dpd_sync
    import dpd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pd_pair_t d,
    output pd_pair_t q
);
    pd_pair_t stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[gi] <= '0;
                    else     stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dpd_edge_detect.sv
module dpd_edge_detect
    import dpd_pkg::*;
#(
    parameter bit FALL_EDGE = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  pd_pair_t cur,
    output pd_pair_t hits
);
    pd_pair_t hist;

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= cur;
    end

    always_comb begin
        hits.fb_s  = edge_hit(hist.fb_s,  cur.fb_s,  FALL_EDGE);
        hits.ref_s = edge_hit(hist.ref_s, cur.ref_s, FALL_EDGE);
    end

    // An active transition cannot repeat in the very next sample
    AST_FB_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        hits.fb_s |=> !hits.fb_s);                               // R5
    AST_REF_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        hits.ref_s |=> !hits.ref_s);                             // R5
endmodule

// File: rtl/dpd_sr_core.sv
module dpd_sr_core
    import dpd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sr_cmd_t cmd,
    output logic    q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_SET:   q <= 1'b1;
                CMD_CLEAR: q <= 1'b0;
                default:   q <= q;
            endcase
        end
    end

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SET) |=> q);                                 // R2
    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CLEAR) |=> !q);                              // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> $stable(q));                       // R4
    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !q);                                             // R6
endmodule

// File: rtl/dual_phase_det.sv
module dual_phase_det
    import dpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit FALL_EDGE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_x,
    input  logic ref_e,
    input  logic fb_in,
    output logic xor_err,
    output logic edge_err
);
    localparam int SYNC_D = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    pd_pair_t raw_pair;
    pd_pair_t sync_pair;
    pd_pair_t hit_pair;
    sr_cmd_t  sr_cmd;

    // Combinational detector: error is high while the inputs disagree
    assign xor_err = ref_x ^ fb_in;

    assign raw_pair = '{ref_s: ref_e, fb_s: fb_in};

    dpd_sync #(.STAGES(SYNC_D)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pair),
        .q   (sync_pair)
    );

    dpd_edge_detect #(.FALL_EDGE(FALL_EDGE)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .cur  (sync_pair),
        .hits (hit_pair)
    );

    assign sr_cmd = decide(hit_pair);

    dpd_sr_core u_core (
        .clk (clk),
        .rst (rst),
        .cmd (sr_cmd),
        .q   (edge_err)
    );
endmodule

// File: tb/sim_dual_phase_det.sv
`timescale 1ns/1ps
module sim_dual_phase_det;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_x = 1'b0, ref_e = 1'b0, fb_in = 1'b0;
    logic xor_err, edge_err;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // behavioural model state
    int m_ref_q[$];
    int m_fb_q[$];
    int m_ref_hist = 0, m_fb_hist = 0, m_out = 0;
    logic obs_x, obs_e;

    always #2.5 clk = ~clk;

    dual_phase_det #(.SYNC_STAGES(S), .FALL_EDGE(1'b1)) u0 (
        .clk(clk), .rst(rst), .ref_x(ref_x), .ref_e(ref_e), .fb_in(fb_in),
        .xor_err(xor_err), .edge_err(edge_err)
    );

    task automatic model_clear();
        m_ref_q.delete(); m_fb_q.delete();
        for (int i = 0; i < S; i++) begin m_ref_q.push_back(0); m_fb_q.push_back(0); end
        m_ref_hist = 0; m_fb_hist = 0; m_out = 0;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one sample, compare both outputs, then advance the model one edge
    task automatic step(input logic x, input logic e, input logic b,
                        input logic r, input string tag);
        int cr, cb, fr, fbk;
        @(negedge clk);
        ref_x = x; ref_e = e; fb_in = b; rst = r;
        #1;
        obs_x = xor_err; obs_e = edge_err;
        check("R1", obs_x, x ^ b);
        check(tag, obs_e, m_out[0]);
        if (r) begin
            model_clear();
        end else begin
            cr = m_ref_q[S-1]; cb = m_fb_q[S-1];
            fr  = (m_ref_hist == 1 && cr == 0);
            fbk = (m_fb_hist == 1 && cb == 0);
            if (fbk && !fr) m_out = 1;
            else if (fr && !fbk) m_out = 0;
            m_ref_hist = cr; m_fb_hist = cb;
            void'(m_ref_q.pop_back()); void'(m_fb_q.pop_back());
            m_ref_q.push_front(int'(e)); m_fb_q.push_front(int'(b));
        end
    endtask

    task automatic hold(input int n, input logic x, input logic e,
                        input logic b, input string tag);
        for (int i = 0; i < n; i++) step(x, e, b, 1'b0, tag);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int hx, he;
        model_clear();
        // R6: reset with inputs high, then release: no edge seen
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R6");
        hold(6, 1'b0, 1'b1, 1'b1, "R6");
        check("R6", edge_err, 1'b0);
        // R1: all four input combinations
        hold(1, 1'b0, 1'b1, 1'b1, "R5");
        hold(1, 1'b1, 1'b1, 1'b1, "R5");
        hold(1, 1'b1, 1'b1, 1'b0, "R2");
        hold(1, 1'b0, 1'b1, 1'b0, "R2");
        // R2: feedback fall (already applied) sets output after latency
        hold(5, 1'b0, 1'b1, 1'b0, "R2");
        check("R2", obs_e, 1'b1);
        // R5: rising feedback and steady reference leave output high
        hold(5, 1'b0, 1'b1, 1'b1, "R5");
        check("R5", obs_e, 1'b1);
        // R3: reference fall clears
        hold(5, 1'b0, 1'b0, 1'b1, "R3");
        check("R3", obs_e, 1'b0);
        // R5: reference rises, no change
        hold(5, 1'b0, 1'b1, 1'b1, "R5");
        check("R5", obs_e, 1'b0);
        // R4: both fall together while low -> stays low
        hold(5, 1'b0, 1'b0, 1'b0, "R4");
        check("R4", obs_e, 1'b0);
        // set high, then both rise and fall together -> stays high
        hold(4, 1'b0, 1'b1, 1'b1, "R5");
        hold(5, 1'b0, 1'b1, 1'b0, "R2");
        hold(4, 1'b0, 1'b1, 1'b1, "R5");
        hold(5, 1'b0, 1'b0, 1'b0, "R4");
        check("R4", obs_e, 1'b1);
        // R7: zero-error patterns, period 8
        hx = 0; he = 0;
        for (int i = 0; i < 48; i++) begin
            int p;
            p = i % 8;
            step(p >= 2 && p <= 5, p <= 3, p >= 4, 1'b0, "R7");
            if (i >= 16) begin hx += int'(obs_x); he += int'(obs_e); end
        end
        check("R7", hx == 16, 1'b1);
        check("R7", he == 16, 1'b1);
        // R6: reset mid-run while output high
        hold(2, 1'b0, 1'b1, 1'b1, "R5");
        hold(5, 1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        check("R6", obs_e, 1'b0);
        hold(6, 1'b0, 1'b1, 1'b0, "R6");
        check("R6", obs_e, 1'b0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule